// File: doc/BRIEF.md
# Mode-Banked Register File Controller

This block holds the sixteen 32-bit general registers of a processor that has several privileged operating modes, together with the current status word and one saved status word for each privileged mode group. Every value of the 5-bit mode field selects a bank. The bank decides which physical copies of registers r8 to r14 the program sees. Registers r0 to r7 and r15 are shared by every bank. The fast-interrupt bank has its own r8 to r14. Every other bank has private copies of r13 and r14 only, and shares r8 to r12 with the user bank.

The working copies are what the read and write ports normally reach. When a status write changes the bank, the block saves the outgoing working copies into shadow storage and loads the incoming ones, all on the same clock edge. Each read and write port can also name a mode explicitly. It then reaches that mode's copy without disturbing the working view. Status writes carry a 4-bit field mask and a current/saved target. The block limits them by privilege: user code can change only the condition flags.

Top module: `modebank_regfile`

## Requirements
- R1: The mode field is status bits [4:0]. Mode values 0/16 select the user bank, 1/17 fast-interrupt, 2/18 interrupt, 3/19 supervisor, 23 abort and 27 undefined. Every other value, including every value above 27, selects a dummy bank with its own r13/r14.
- R2: r0–r7 and r15 are one set of storage seen identically from every mode. A value written in one mode reads back unchanged in any other.
- R3: The fast-interrupt bank has private r8–r14. All other banks share r8–r12 with the user bank, so leaving fast-interrupt mode shows the user r8–r12 values again.
- R4: Each of the user, interrupt, supervisor, abort, undefined and dummy banks has its own r13 and r14.
- R5: A read or write whose mode-select input is 1 reaches the copy belonging to the bank of the named mode. If that bank is not the current bank, the registers visible in the current mode do not change.
- R6: When the dummy bank is left, its r13/r14 copies are cleared to zero. Entering it again, or reading it by name, returns 0.
- R7: In the user bank, a status write to the current word changes only the flag bits [31:28], and only when field-mask bit 3 is set. All other status bits stay unchanged.
- R8: In any non-user bank, field mask 4'b1001 writes the whole status word. Otherwise mask bit 0 writes only bits [7:0] (interrupt disables and mode), otherwise mask bit 3 writes only bits [31:28], and any other mask changes nothing.
- R9: Saved-status writes are ignored, and saved-status reads return 0, in the user and dummy banks. Elsewhere a write with the saved target uses the saved word of the current bank under the R8 mask rules, and a read returns the saved word of the current or the named bank.
- R10: `priv_o` is 1 exactly when status bits [1:0] are not both 0.
- R11: A bank change takes one clock. The new status word and the swapped registers appear together on the cycle after the write. A register write issued in the same cycle lands in the outgoing bank.
- R12: After a synchronous reset (rst_n low at a clock edge) the status word is 32'h0000_00D3 (supervisor mode, both interrupts disabled). All general registers and all saved status words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_addr | input | 4 | Read port A register number |
| ra_msel | input | 1 | Read port A uses ra_mode instead of current mode |
| ra_mode | input | 5 | Read port A explicit mode |
| ra_data | output | DW | Read port A data |
| rb_addr | input | 4 | Read port B register number |
| rb_msel | input | 1 | Read port B uses rb_mode instead of current mode |
| rb_mode | input | 5 | Read port B explicit mode |
| rb_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Write register number |
| wr_msel | input | 1 | Write uses wr_mode instead of current mode |
| wr_mode | input | 5 | Write explicit mode |
| wr_data | input | DW | Write data |
| sw_en | input | 1 | Status write enable |
| sw_field | input | 4 | Status field mask |
| sw_saved | input | 1 | 1 targets the saved word, 0 the current word |
| sw_data | input | 32 | Status write data |
| ss_msel | input | 1 | Saved-status read uses ss_mode |
| ss_mode | input | 5 | Saved-status read explicit mode |
| ss_data | output | 32 | Saved-status read data |
| psr_o | output | 32 | Current status word |
| priv_o | output | 1 | Non-user-privilege indicator |

## Verification
A wrong shadow slot or a missed save shows up only when a port next looks at that copy. This happens either on the bank change that restores it, or at once through a named-mode read. The bench therefore reads named copies of other banks straight after every switch, so that a corrupted save shows on the very next cycle. A wrong status merge or a wrong bank decode shows on `psr_o` and on the read data one cycle after the write. The reference model keeps one logical copy per register and bank, with no swapping. It is compared against all read ports on every clock, so any divergence appears on the first cycle a port selects the damaged register.

// File: rtl/mbr_pkg.sv
// Package: shared bank type, mode decode and status-field merge rules.
// Assumes a 32-bit status word with flags in [31:28] and control in [7:0].
package mbr_pkg;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5,
        BK_DUM = 3'd6
    } bank_e;

    localparam int NARCH   = 16;  // architectural registers
    localparam int NBANK   = 7;   // banks including dummy
    localparam int SH_N    = 7;   // shadowed registers r8..r14
    localparam int SH_BASE = 8;   // first shadowed register
    localparam int PAIR_J  = 5;   // offset of r13 within shadow row
    localparam int PSR_W   = 32;

    localparam logic [3:0] FLD_FULL = 4'b1001;

    // Map a 5-bit mode value to its bank.
    function automatic bank_e mode_bank(input logic [4:0] m);
        case (m)
            5'd0, 5'd16: return BK_USR;
            5'd1, 5'd17: return BK_FIQ;
            5'd2, 5'd18: return BK_IRQ;
            5'd3, 5'd19: return BK_SVC;
            5'd23:       return BK_ABT;
            5'd27:       return BK_UND;
            default:     return BK_DUM;
        endcase
    endfunction

    // Apply a field-masked status write under the privilege rules.
    function automatic logic [PSR_W-1:0] psr_merge(
        input logic [PSR_W-1:0] old,
        input logic [PSR_W-1:0] data,
        input logic [3:0]       fld,
        input logic             priv
    );
        if (!priv)
            return fld[3] ? {data[31:28], old[27:0]} : old;
        if (fld == FLD_FULL)
            return data;
        if (fld[0])
            return {old[31:8], data[7:0]};
        if (fld[3])
            return {data[31:28], old[27:0]};
        return old;
    endfunction

endpackage

// File: rtl/mbr_read_port.sv
// Module: one combinational register read port.
// Resolves the target bank (current or named) and picks the working copy
// or the proper shadow copy. Assumes shadow rows hold r8..r14 per bank.
module mbr_read_port
    import mbr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    addr,
    input  logic          msel,
    input  logic [4:0]    mode,
    input  bank_e         cur_bank,
    input  logic [DW-1:0] wk [NARCH],
    input  logic [DW-1:0] sh [NBANK][SH_N],
    output logic [DW-1:0] data
);

    bank_e      tgt;
    logic [2:0] off;

    // Choose which copy of the addressed register this port sees.
    always_comb begin
        tgt  = msel ? mode_bank(mode) : cur_bank;
        off  = addr[2:0];
        data = wk[addr];
        if (tgt != cur_bank && addr >= 4'd8 && addr <= 4'd14) begin
            if (addr >= 4'd13)
                data = sh[tgt][off];
            else if (tgt == BK_FIQ)
                data = sh[BK_FIQ][off];
            else if (cur_bank == BK_FIQ)
                data = sh[BK_USR][off];
        end
    end

endmodule

// File: rtl/mbr_reg_store.sv
// Module: working registers plus shadow rows, with bank swap on switch.
// A port write is applied first in the outgoing bank's view; the swap
// then uses the post-write values. Assumes cur_bank != nxt_bank when
// switch_en is high.
module mbr_reg_store
    import mbr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic          wr_msel,
    input  logic [4:0]    wr_mode,
    input  logic [DW-1:0] wr_data,
    input  bank_e         cur_bank,
    input  bank_e         nxt_bank,
    input  logic          switch_en,
    output logic [DW-1:0] wk [NARCH],
    output logic [DW-1:0] sh [NBANK][SH_N]
);

    logic [DW-1:0] wk_w [NARCH];
    logic [DW-1:0] sh_w [NBANK][SH_N];
    logic [DW-1:0] wk_n [NARCH];
    logic [DW-1:0] sh_n [NBANK][SH_N];
    bank_e         wtgt;
    logic [2:0]    woff;

    // Stage 1: apply the register write port in the current bank's view.
    always_comb begin
        wk_w = wk;
        sh_w = sh;
        wtgt = wr_msel ? mode_bank(wr_mode) : cur_bank;
        woff = wr_addr[2:0];
        if (wr_en) begin
            if (wtgt == cur_bank || wr_addr < 4'd8 || wr_addr == 4'd15)
                wk_w[wr_addr] = wr_data;
            else if (wr_addr >= 4'd13)
                sh_w[wtgt][woff] = wr_data;
            else if (wtgt == BK_FIQ)
                sh_w[BK_FIQ][woff] = wr_data;
            else if (cur_bank == BK_FIQ)
                sh_w[BK_USR][woff] = wr_data;
            else
                wk_w[wr_addr] = wr_data;
        end
    end

    // Stage 2: save outgoing copies and load incoming copies on a switch.
    always_comb begin
        wk_n = wk_w;
        sh_n = sh_w;
        if (switch_en) begin
            for (int j = 0; j < SH_N; j++) begin
                if (j < PAIR_J && cur_bank != BK_FIQ && nxt_bank == BK_FIQ)
                    sh_n[BK_USR][j] = wk_w[SH_BASE+j];
                if (cur_bank == BK_DUM)
                    sh_n[BK_DUM][j] = '0;
                else if (cur_bank == BK_FIQ)
                    sh_n[BK_FIQ][j] = wk_w[SH_BASE+j];
                else if (j >= PAIR_J)
                    sh_n[cur_bank][j] = wk_w[SH_BASE+j];

                if (nxt_bank == BK_FIQ)
                    wk_n[SH_BASE+j] = sh_w[BK_FIQ][j];
                else if (j >= PAIR_J)
                    wk_n[SH_BASE+j] = sh_w[nxt_bank][j];
                else if (cur_bank == BK_FIQ)
                    wk_n[SH_BASE+j] = sh_w[BK_USR][j];
            end
        end
    end

    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++)
                wk[i] <= '0;
            for (int b = 0; b < NBANK; b++)
                for (int j = 0; j < SH_N; j++)
                    sh[b][j] <= '0;
        end else begin
            wk <= wk_n;
            sh <= sh_n;
        end
    end

endmodule

// File: rtl/mbr_psr_unit.sv
// Module: status-write decoder. Produces the next current status word and
// the saved-status update for the current bank. Purely combinational.
// Assumes saved words exist only for fast-interrupt..undefined banks.
module mbr_psr_unit
    import mbr_pkg::*;
(
    input  logic             sw_en,
    input  logic [3:0]       sw_field,
    input  logic             sw_saved,
    input  logic [PSR_W-1:0] sw_data,
    input  logic [PSR_W-1:0] psr_q,
    input  logic [PSR_W-1:0] cur_spsr,
    input  bank_e            cur_bank,
    output logic [PSR_W-1:0] psr_n,
    output logic             spsr_we,
    output logic [PSR_W-1:0] spsr_n
);

    logic priv_bank;
    logic has_saved;

    // Decide the targets and merged values of a status write.
    always_comb begin
        priv_bank = (cur_bank != BK_USR);
        has_saved = priv_bank && (cur_bank != BK_DUM);
        psr_n     = psr_q;
        spsr_we   = 1'b0;
        spsr_n    = cur_spsr;
        if (sw_en) begin
            if (!sw_saved) begin
                psr_n = psr_merge(psr_q, sw_data, sw_field, priv_bank);
            end else if (has_saved) begin
                spsr_we = 1'b1;
                spsr_n  = psr_merge(cur_spsr, sw_data, sw_field, 1'b1);
            end
        end
    end

endmodule

// File: rtl/modebank_regfile.sv
// Module: top of the mode-banked register file controller.
// Holds the current status word and saved status words, decodes the bank
// from the mode field, and drives the register store and two read ports.
// Assumes at most one status write and one register write per cycle.
module modebank_regfile
    import mbr_pkg::*;
#(
    parameter int               DW        = 32,
    parameter logic [PSR_W-1:0] RESET_PSR = 32'h0000_00D3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ra_addr,
    input  logic             ra_msel,
    input  logic [4:0]       ra_mode,
    output logic [DW-1:0]    ra_data,
    input  logic [3:0]       rb_addr,
    input  logic             rb_msel,
    input  logic [4:0]       rb_mode,
    output logic [DW-1:0]    rb_data,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic             wr_msel,
    input  logic [4:0]       wr_mode,
    input  logic [DW-1:0]    wr_data,
    input  logic             sw_en,
    input  logic [3:0]       sw_field,
    input  logic             sw_saved,
    input  logic [PSR_W-1:0] sw_data,
    input  logic             ss_msel,
    input  logic [4:0]       ss_mode,
    output logic [PSR_W-1:0] ss_data,
    output logic [PSR_W-1:0] psr_o,
    output logic             priv_o
);

    localparam int NRP = 2;

    logic [PSR_W-1:0] psr_q;
    logic [PSR_W-1:0] psr_n;
    logic [PSR_W-1:0] spsr_q [NBANK];
    logic [PSR_W-1:0] spsr_n;
    logic             spsr_we;
    bank_e            cur_bank;
    bank_e            nxt_bank;
    bank_e            ss_bank;
    logic             switch_en;
    logic [DW-1:0]    wk [NARCH];
    logic [DW-1:0]    sh [NBANK][SH_N];

    logic [3:0]       rp_addr [NRP];
    logic             rp_msel [NRP];
    logic [4:0]       rp_mode [NRP];
    logic [DW-1:0]    rp_data [NRP];

    // Bank decode of the current and the next status word.
    always_comb begin
        cur_bank  = mode_bank(psr_q[4:0]);
        nxt_bank  = mode_bank(psr_n[4:0]);
        switch_en = (nxt_bank != cur_bank);
    end

    mbr_psr_unit u_psr (
        .sw_en    (sw_en),
        .sw_field (sw_field),
        .sw_saved (sw_saved),
        .sw_data  (sw_data),
        .psr_q    (psr_q),
        .cur_spsr (spsr_q[cur_bank]),
        .cur_bank (cur_bank),
        .psr_n    (psr_n),
        .spsr_we  (spsr_we),
        .spsr_n   (spsr_n)
    );

    // Status and saved-status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psr_q <= RESET_PSR;
            for (int b = 0; b < NBANK; b++)
                spsr_q[b] <= '0;
        end else begin
            psr_q <= psr_n;
            if (spsr_we)
                spsr_q[cur_bank] <= spsr_n;
        end
    end

    mbr_reg_store #(.DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_msel   (wr_msel),
        .wr_mode   (wr_mode),
        .wr_data   (wr_data),
        .cur_bank  (cur_bank),
        .nxt_bank  (nxt_bank),
        .switch_en (switch_en),
        .wk        (wk),
        .sh        (sh)
    );

    // Gather the two read ports into arrays for the generate loop.
    always_comb begin
        rp_addr[0] = ra_addr;  rp_msel[0] = ra_msel;  rp_mode[0] = ra_mode;
        rp_addr[1] = rb_addr;  rp_msel[1] = rb_msel;  rp_mode[1] = rb_mode;
    end

    for (genvar g = 0; g < NRP; g++) begin : g_rd
        mbr_read_port #(.DW(DW)) u_rd (
            .addr     (rp_addr[g]),
            .msel     (rp_msel[g]),
            .mode     (rp_mode[g]),
            .cur_bank (cur_bank),
            .wk       (wk),
            .sh       (sh),
            .data     (rp_data[g])
        );
    end

    // Saved-status read: zero for banks without a saved word.
    always_comb begin
        ss_bank = ss_msel ? mode_bank(ss_mode) : cur_bank;
        if (ss_bank == BK_USR || ss_bank == BK_DUM)
            ss_data = '0;
        else
            ss_data = spsr_q[ss_bank];
    end

    assign ra_data = rp_data[0];
    assign rb_data = rp_data[1];
    assign psr_o   = psr_q;
    assign priv_o  = (psr_q[1:0] != 2'b00);

endmodule

// File: rtl/mbr_checker.sv
// Module: assertion checker for modebank_regfile, bound to every instance.
// Observes ports and internal bank state; drives nothing.
module mbr_checker
    import mbr_pkg::*;
#(
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             sw_en,
    input logic             sw_saved,
    input logic [3:0]       sw_field,
    input logic [2:0]       cur_bank,
    input logic [2:0]       nxt_bank,
    input logic             switch_en,
    input logic [PSR_W-1:0] psr,
    input logic [DW-1:0]    wk_r0,
    input logic [DW-1:0]    wk_r8,
    input logic [DW-1:0]    sh_usr_r8,
    input logic [DW-1:0]    sh_dum_r14
);

    // R7: user-bank current-status write leaves bits [27:0] alone.
    a_r7_user_flags_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !sw_saved && cur_bank == BK_USR) |=> $stable(psr[27:0]));

    // R8: control-only field write keeps the upper status bits.
    a_r8_ctrl_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !sw_saved && cur_bank != BK_USR && sw_field == 4'b0001)
        |=> $stable(psr[31:8]));

    // R9: a saved-status write never alters the current status word.
    a_r9_saved_spares_current: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && sw_saved) |=> $stable(psr));

    // R2: without a register write, shared r0 holds across any switch.
    a_r2_shared_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(wk_r0));

    // R3: entering fast-interrupt bank saves working r8 into the user copy.
    a_r3_fiq_entry_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_en && nxt_bank == BK_FIQ && cur_bank != BK_FIQ && !wr_en)
        |=> (sh_usr_r8 == $past(wk_r8)));

    // R6: leaving the dummy bank clears its r14 copy.
    a_r6_dummy_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_en && cur_bank == BK_DUM) |=> (sh_dum_r14 == '0));

endmodule

bind modebank_regfile mbr_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sw_en      (sw_en),
    .sw_saved   (sw_saved),
    .sw_field   (sw_field),
    .cur_bank   (cur_bank),
    .nxt_bank   (nxt_bank),
    .switch_en  (switch_en),
    .psr        (psr_q),
    .wk_r0      (wk[0]),
    .wk_r8      (wk[8]),
    .sh_usr_r8  (sh[0][0]),
    .sh_dum_r14 (sh[6][6])
);

// File: tb/modebank_regfile_bench.sv
// Bench: behavioural reference model with one logical copy per register
// and bank (no swapping), compared against all outputs on every clock.
module modebank_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  ra_addr, rb_addr, wr_addr;
    logic        ra_msel, rb_msel, wr_msel, ss_msel;
    logic [4:0]  ra_mode, rb_mode, wr_mode, ss_mode;
    logic [31:0] ra_data, rb_data, wr_data, sw_data, ss_data, psr_o;
    logic        wr_en, sw_en, sw_saved, priv_o;
    logic [3:0]  sw_field;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modebank_regfile u_modebank_regfile (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(ra_addr), .ra_msel(ra_msel), .ra_mode(ra_mode), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_msel(rb_msel), .rb_mode(rb_mode), .rb_data(rb_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_msel(wr_msel), .wr_mode(wr_mode),
        .wr_data(wr_data),
        .sw_en(sw_en), .sw_field(sw_field), .sw_saved(sw_saved), .sw_data(sw_data),
        .ss_msel(ss_msel), .ss_mode(ss_mode), .ss_data(ss_data),
        .psr_o(psr_o), .priv_o(priv_o)
    );

    // ---------------- reference model ----------------
    // Logical banks: 0 user,1 fast-int,2 int,3 supervisor,4 abort,5 undef,6 dummy
    logic [31:0] m_lo [8];
    logic [31:0] m_pc;
    logic [31:0] m_usr [5];
    logic [31:0] m_fiq [7];
    logic [31:0] m_pair [7][2];
    logic [31:0] m_psr;
    logic [31:0] m_sps [7];

    function automatic int mbank(input logic [4:0] m);
        case (m)
            5'd0, 5'd16: return 0;
            5'd1, 5'd17: return 1;
            5'd2, 5'd18: return 2;
            5'd3, 5'd19: return 3;
            5'd23:       return 4;
            5'd27:       return 5;
            default:     return 6;
        endcase
    endfunction

    function automatic logic [31:0] m_rd(input int a, input int b);
        if (a < 8)  return m_lo[a];
        if (a == 15) return m_pc;
        if (b == 1) return m_fiq[a-8];
        if (a < 13) return m_usr[a-8];
        return m_pair[b][a-13];
    endfunction

    task automatic m_wr(input int a, input int b, input logic [31:0] d);
        if (a < 8)        m_lo[a] = d;
        else if (a == 15) m_pc = d;
        else if (b == 1)  m_fiq[a-8] = d;
        else if (a < 13)  m_usr[a-8] = d;
        else              m_pair[b][a-13] = d;
    endtask

    function automatic logic [31:0] m_merge(input logic [31:0] o, input logic [31:0] d,
                                            input logic [3:0] f, input bit pv);
        if (!pv) return f[3] ? {d[31:28], o[27:0]} : o;
        if (f == 4'b1001) return d;
        if (f[0]) return {o[31:8], d[7:0]};
        if (f[3]) return {d[31:28], o[27:0]};
        return o;
    endfunction

    task automatic m_update();
        int cb, nb;
        logic [31:0] np;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_lo[i] = '0;
            m_pc = '0;
            for (int i = 0; i < 5; i++) m_usr[i] = '0;
            for (int i = 0; i < 7; i++) begin
                m_fiq[i] = '0; m_pair[i][0] = '0; m_pair[i][1] = '0; m_sps[i] = '0;
            end
            m_psr = 32'h0000_00D3;
            return;
        end
        cb = mbank(m_psr[4:0]);
        if (wr_en) m_wr(int'(wr_addr), wr_msel ? mbank(wr_mode) : cb, wr_data);
        if (sw_en) begin
            if (!sw_saved) begin
                np = m_merge(m_psr, sw_data, sw_field, cb != 0);
                nb = mbank(np[4:0]);
                if (nb != cb && cb == 6) begin
                    m_pair[6][0] = '0; m_pair[6][1] = '0;
                end
                m_psr = np;
            end else if (cb != 0 && cb != 6) begin
                m_sps[cb] = m_merge(m_sps[cb], sw_data, sw_field, 1'b1);
            end
        end
    endtask

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: model steps at the edge, outputs compared 1 time unit later.
    task automatic cyc(input string tag);
        int cb, sb;
        @(posedge clk);
        m_update();
        #1;
        cb = mbank(m_psr[4:0]);
        sb = ss_msel ? mbank(ss_mode) : cb;
        chk(tag, "psr_o", psr_o, m_psr);
        chk(tag, "priv_o", {31'b0, priv_o}, {31'b0, (m_psr[1:0] != 2'b00)});
        chk(tag, "ra_data", ra_data, m_rd(int'(ra_addr), ra_msel ? mbank(ra_mode) : cb));
        chk(tag, "rb_data", rb_data, m_rd(int'(rb_addr), rb_msel ? mbank(rb_mode) : cb));
        chk(tag, "ss_data", ss_data, (sb == 0 || sb == 6) ? 32'h0 : m_sps[sb]);
        wr_en = 1'b0;
        sw_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input bit ms, input logic [4:0] m,
                      input logic [3:0] b, input bit msb, input logic [4:0] mb);
        ra_addr = a; ra_msel = ms; ra_mode = m;
        rb_addr = b; rb_msel = msb; rb_mode = mb;
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_msel = 1'b0; wr_data = d;
    endtask

    task automatic wreg_m(input logic [3:0] a, input logic [4:0] m, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_msel = 1'b1; wr_mode = m; wr_data = d;
    endtask

    task automatic wpsr(input logic [3:0] f, input logic [31:0] d, input bit sv);
        sw_en = 1'b1; sw_field = f; sw_data = d; sw_saved = sv;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 0; wr_addr = 0; wr_msel = 0; wr_mode = 0; wr_data = 0;
        sw_en = 0; sw_field = 0; sw_saved = 0; sw_data = 0;
        ss_msel = 0; ss_mode = 0;
        rd(4'd0, 0, 5'd0, 4'd13, 0, 5'd0);
        #2;
        // R12: reset state
        cyc("R12"); cyc("R12");
        chk("R12", "reset psr", psr_o, 32'h0000_00D3);
        chk("R12", "reset r13", rb_data, 32'h0);
        rst_n = 1'b1;
        cyc("R12");

        // R2: fill all registers in supervisor mode, read each back
        for (int i = 0; i < 16; i++) begin
            wreg(4'(i), 32'h5000_0000 + i);
            rd(4'(i), 0, 5'd0, 4'd0, 0, 5'd0);
            cyc("R2");
        end
        chk("R2", "svc r15", ra_data, 32'h5000_000F);

        // R11: switch to interrupt mode, r13 is the interrupt copy (0)
        wpsr(4'b0001, 32'h0000_00D2, 0);
        rd(4'd13, 0, 5'd0, 4'd0, 0, 5'd0);
        cyc("R11");
        chk("R11", "irq psr", psr_o, 32'h0000_00D2);
        chk("R4", "irq r13 fresh", ra_data, 32'h0);
        chk("R2", "r0 shared", rb_data, 32'h5000_0000);
        wreg(4'd13, 32'h1313_0002);
        cyc("R4");
        // R5: named read of supervisor r13 from interrupt mode
        rd(4'd13, 1, 5'd19, 4'd13, 0, 5'd0);
        cyc("R5");
        chk("R5", "named svc r13", ra_data, 32'h5000_000D);
        chk("R4", "irq r13", rb_data, 32'h1313_0002);
        wreg_m(4'd14, 5'd19, 32'hAAAA_0014);
        rd(4'd14, 0, 5'd0, 4'd14, 1, 5'd19);
        cyc("R5");
        chk("R5", "working r14 untouched", ra_data, 32'h0);
        chk("R5", "named svc r14", rb_data, 32'hAAAA_0014);

        // R3: enter fast-interrupt mode, write private r8..r14
        wpsr(4'b0001, 32'h0000_00D1, 0);
        rd(4'd8, 0, 5'd0, 4'd8, 1, 5'd16);
        cyc("R3");
        for (int i = 8; i < 15; i++) begin
            wreg(4'(i), 32'hF000_0000 + i);
            cyc("R3");
        end
        rd(4'd8, 0, 5'd0, 4'd8, 1, 5'd16);
        cyc("R5");
        chk("R3", "fiq r8", ra_data, 32'hF000_0008);
        chk("R5", "named user r8", rb_data, 32'h5000_0008);
        wreg_m(4'd9, 5'd16, 32'h0909_0909);
        cyc("R5");
        // leave fast-interrupt for supervisor: user r8..r12 reappear
        wpsr(4'b0001, 32'h0000_00D3, 0);
        rd(4'd9, 0, 5'd0, 4'd14, 0, 5'd0);
        cyc("R3");
        chk("R3", "svc r9 is user copy", ra_data, 32'h0909_0909);
        chk("R4", "svc r14 restored", rb_data, 32'hAAAA_0014);

        // R1/R6: dummy mode 5, then leave and read it by name
        wpsr(4'b0001, 32'h0000_00C5, 0);
        rd(4'd13, 0, 5'd0, 4'd13, 1, 5'd19);
        cyc("R1");
        chk("R10", "priv in mode 5", {31'b0, priv_o}, 32'h1);
        wreg(4'd13, 32'hDDDD_0013);
        wpsr(4'b1001, 32'hFFFF_FFFF, 1);
        ss_msel = 0;
        cyc("R9");
        chk("R9", "dummy saved read", ss_data, 32'h0);
        wpsr(4'b0001, 32'h0000_00D3, 0);
        rd(4'd13, 1, 5'd5, 4'd13, 1, 5'd31);
        cyc("R6");
        chk("R6", "dummy r13 cleared", ra_data, 32'h0);
        chk("R1", "mode 31 is dummy", rb_data, 32'h0);
        // abort and undefined banks
        wpsr(4'b0001, 32'h0000_00D7, 0);
        cyc("R1");
        wreg(4'd13, 32'hAB00_0013);
        cyc("R4");
        wpsr(4'b0001, 32'h0000_00DB, 0);
        rd(4'd13, 0, 5'd0, 4'd13, 1, 5'd23);
        cyc("R1");
        chk("R1", "undef r13 fresh", ra_data, 32'h0);
        chk("R1", "abort r13 named", rb_data, 32'hAB00_0013);
        wpsr(4'b0001, 32'h0000_00D3, 0);
        cyc("R1");

        // R8: field masks in supervisor mode
        wpsr(4'b1000, 32'hA000_0000, 0);
        cyc("R8");
        chk("R8", "flags only", psr_o, 32'hA000_00D3);
        wpsr(4'b0001, 32'h5F00_00D3, 0);
        cyc("R8");
        chk("R8", "control only", psr_o, 32'hA000_00D3);
        wpsr(4'b1001, 32'h5123_40D3, 0);
        cyc("R8");
        chk("R8", "full word", psr_o, 32'h5123_40D3);
        wpsr(4'b0010, 32'hFFFF_FFFF, 0);
        cyc("R8");
        chk("R8", "mask 0010 no effect", psr_o, 32'h5123_40D3);
        wpsr(4'b1011, 32'h0000_00D3, 0);
        cyc("R8");

        // R9: saved status in supervisor, read from interrupt mode by name
        wpsr(4'b1001, 32'h1234_56D0, 1);
        cyc("R9");
        chk("R9", "svc saved", ss_data, 32'h1234_56D0);
        wpsr(4'b0001, 32'h0000_00D2, 0);
        cyc("R9");
        chk("R9", "irq saved fresh", ss_data, 32'h0);
        ss_msel = 1; ss_mode = 5'd3;
        cyc("R9");
        chk("R9", "named svc saved", ss_data, 32'h1234_56D0);
        ss_msel = 0;

        // R11: register write in the same cycle as a switch lands in old bank
        wreg(4'd13, 32'h7777_0013);
        wpsr(4'b0001, 32'h0000_00D3, 0);
        rd(4'd13, 1, 5'd18, 4'd13, 0, 5'd0);
        cyc("R11");
        chk("R11", "write landed in irq", ra_data, 32'h7777_0013);
        chk("R11", "svc r13 visible", rb_data, 32'h5000_000D);

        // R7/R10: user mode privilege limits
        wpsr(4'b0001, 32'h0000_0010, 0);
        cyc("R10");
        chk("R10", "user priv low", {31'b0, priv_o}, 32'h0);
        wpsr(4'b1001, 32'hF000_00D3, 0);
        cyc("R7");
        chk("R7", "user flags only", psr_o, {4'hF, 28'h0000_010} | (psr_o & 32'h0FFF_FF00) );
        chk("R7", "user mode kept", {27'b0, psr_o[4:0]}, 32'h10);
        wpsr(4'b0001, 32'h0000_00D3, 0);
        cyc("R7");
        chk("R7", "user control ignored", {27'b0, psr_o[4:0]}, 32'h10);
        wpsr(4'b1001, 32'hFFFF_FFFF, 1);
        cyc("R9");

        // R1: random sweep over all mode encodings, compared every clock
        rst_n = 1'b0; cyc("R12"); rst_n = 1'b1;
        for (int k = 0; k < 600; k++) begin
            if (($urandom % 50) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            if ($urandom % 2) begin
                wr_en = 1'b1; wr_addr = 4'($urandom); wr_msel = 1'($urandom);
                wr_mode = 5'($urandom); wr_data = $urandom;
            end
            if (($urandom % 3) == 0) begin
                sw_en = 1'b1; sw_field = 4'($urandom); sw_saved = 1'($urandom);
                sw_data = {$urandom} & 32'hF000_00FF;
            end
            rd(4'($urandom), 1'($urandom), 5'($urandom),
               4'(8 + $urandom % 7), 1'($urandom), 5'($urandom));
            ss_msel = 1'($urandom); ss_mode = 5'($urandom);
            cyc("R1");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule